// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Controller

This block is the digital part of a frequency synthesiser feedback divider built from a 16/17 dual-modulus prescaler and two programmable counters. A 15-bit division ratio is split into an upper count M and a low swallow count A. Each division cycle runs M prescaler cycles. The first A of them divide by 17 and the rest divide by 16, so the input clock is divided by 16*M + A in total. The prescaler is included as a small counter, so the block takes the high-rate input clock directly. Each division cycle ends with one pulse to the phase comparator. A half-rate copy of that pulse train drives a test port.

The controller is a three-state machine. ST_IDLE is entered on reset and lasts one clock. It loads the ratio, holds the prescaler cleared and then moves to ST_SWALLOW if A is non-zero, or to ST_MAIN if A is zero. ST_SWALLOW drives modulus control high, so the prescaler divides by 17. It moves to ST_MAIN on the prescaler tick at which the count of finished prescaler cycles reaches A. ST_MAIN drives modulus control low, so the prescaler divides by 16. On the last prescaler tick of a division cycle, ST_SWALLOW or ST_MAIN reloads the ratio, emits the cycle pulse and re-enters ST_SWALLOW (A non-zero) or ST_MAIN (A zero).

A ratio is taken from the input only at the boundary between division cycles, so a change made part way through a cycle never shortens or stretches that cycle. Ratios below 240 cannot satisfy A <= M for every A, and the block runs them as 240.

Top module: `dmd_feedback_divider`

## Requirements
- R1: While reset is asserted and directly after its release, mod_ctl, div_pulse and div_half are all 0.
- R2: With a steady ratio of at least 240, consecutive div_pulse assertions are exactly 16*M + A input clocks apart, where M = ratio[14:4] and A = ratio[3:0].
- R3: In each division cycle, mod_ctl is high for exactly 17*A input clocks, covering the first A prescaler cycles, and it changes only at prescaler cycle boundaries. When A is 0, mod_ctl stays low.
- R4: div_pulse is high for exactly one input clock per division cycle.
- R5: div_half toggles in the clock where div_pulse is high and at no other time, so its period is twice the division period.
- R6: A ratio written part way through a division cycle does not affect that cycle. It governs the cycle that starts at the next div_pulse.
- R7: Any ratio below 240 (M below 15) is run as M = 15, A = 0, giving a period of 240 input clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | High-rate input clock (the oscillator signal being divided) |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio | input | 15 | Division ratio: bits 14..4 are M, bits 3..0 are A |
| mod_ctl | output | 1 | Prescaler modulus select: 1 selects divide by 17, 0 selects divide by 16 |
| div_pulse | output | 1 | One-clock pulse at the end of each division cycle |
| div_half | output | 1 | Toggles on each div_pulse; feeds the test port |

## Verification
The bench measures the gap between pulses and the mod_ctl high time for each ratio. The directed cases are the smallest legal ratio (240), the smallest M with the largest A (255), the full-scale ratio and ratios under the floor. A swallow counter that is off by one shows up as a period error of 1 or 17 clocks. A broken floor lets A exceed M and gives a period other than 240. Every ratio is written just after a pulse, so the bench can see whether the cycle already in progress keeps its old length. A controller that loads the ratio at once would produce a mixed-length interval. Half-rate toggles are counted per interval, which catches a test output that toggles on prescaler ticks instead of on division cycles.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } dmd_state_e;
endpackage

// File: rtl/dmd_prescaler.sv
module dmd_prescaler #(
    parameter int A_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic mod_hi,
    output logic tick
);
    localparam int CNT_W = A_W + 1;
    localparam logic [CNT_W-1:0] TERM_LO = CNT_W'((2 ** A_W) - 1);
    localparam logic [CNT_W-1:0] TERM_HI = CNT_W'(2 ** A_W);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;

    always_comb begin
        term = mod_hi ? TERM_HI : TERM_LO;
        tick = !clr && (cnt == term);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt == term) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/dmd_swallow_fsm.sv
module dmd_swallow_fsm
    import dmd_pkg::*;
#(
    parameter int RATIO_W = 15,
    parameter int A_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               tick,
    output logic               mod_hi,
    output logic               pre_clr,
    output logic               cycle_end
);
    localparam int M_W = RATIO_W - A_W;
    localparam logic [M_W-1:0] MIN_M = M_W'((2 ** A_W) - 1);

    dmd_state_e     state, state_n;
    logic [M_W-1:0] pcount, pcount_n;
    logic [M_W-1:0] m_cur, m_n;
    logic [A_W-1:0] a_cur, a_n;
    logic           end_n;

    logic [M_W-1:0] raw_m, ld_m;
    logic [A_W-1:0] raw_a, ld_a;
    logic [M_W-1:0] pnext;
    logic           last;

    always_comb begin
        raw_m = ratio[RATIO_W-1:A_W];
        raw_a = ratio[A_W-1:0];
        ld_m  = (raw_m < MIN_M) ? MIN_M : raw_m;
        ld_a  = (raw_m < MIN_M) ? '0 : raw_a;
        pnext = pcount + M_W'(1);
        last  = (pcount == (m_cur - M_W'(1)));
    end

    always_comb begin
        state_n  = state;
        pcount_n = pcount;
        m_n      = m_cur;
        a_n      = a_cur;
        end_n    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                m_n      = ld_m;
                a_n      = ld_a;
                pcount_n = '0;
                state_n  = (ld_a != '0) ? ST_SWALLOW : ST_MAIN;
            end
            ST_SWALLOW, ST_MAIN: begin
                if (tick) begin
                    if (last) begin
                        m_n      = ld_m;
                        a_n      = ld_a;
                        pcount_n = '0;
                        end_n    = 1'b1;
                        state_n  = (ld_a != '0) ? ST_SWALLOW : ST_MAIN;
                    end else begin
                        pcount_n = pnext;
                        state_n  = (pnext < M_W'(a_cur)) ? ST_SWALLOW : ST_MAIN;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pcount    <= '0;
            m_cur     <= MIN_M;
            a_cur     <= '0;
            cycle_end <= 1'b0;
        end else begin
            state     <= state_n;
            pcount    <= pcount_n;
            m_cur     <= m_n;
            a_cur     <= a_n;
            cycle_end <= end_n;
        end
    end

    always_comb begin
        mod_hi  = (state == ST_SWALLOW);
        pre_clr = (state == ST_IDLE);
    end

    // R3
    mod_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && state != ST_IDLE) |=> $stable(mod_hi));

    // R3
    swallow_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWALLOW) |-> (a_cur != '0));

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> !cycle_end);

    // R7
    m_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (m_cur >= MIN_M));
endmodule

// File: rtl/dmd_half_rate.sv
module dmd_half_rate (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic half
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half <= 1'b0;
        end else if (pulse) begin
            half <= !half;
        end
    end

    // R5
    half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (half != $past(half)));

    // R5
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |=> $stable(half));
endmodule

// File: rtl/dmd_feedback_divider.sv
module dmd_feedback_divider #(
    parameter int RATIO_W = 15,
    parameter int A_W     = 4
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio,
    output logic               mod_ctl,
    output logic               div_pulse,
    output logic               div_half
);
    logic tick;
    logic pre_clr;

    dmd_prescaler #(.A_W(A_W)) u_pre (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .clr    (pre_clr),
        .mod_hi (mod_ctl),
        .tick   (tick)
    );

    dmd_swallow_fsm #(.RATIO_W(RATIO_W), .A_W(A_W)) u_fsm (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .ratio     (ratio),
        .tick      (tick),
        .mod_hi    (mod_ctl),
        .pre_clr   (pre_clr),
        .cycle_end (div_pulse)
    );

    dmd_half_rate u_half (
        .clk   (clk_in),
        .rst_n (rst_n),
        .pulse (div_pulse),
        .half  (div_half)
    );
endmodule

// File: tb/test_dmd_feedback_divider.sv
module test_dmd_feedback_divider;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] ratio = 15'd1000;
    logic        mod_ctl, div_pulse, div_half;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;
    int prev_n = 0;

    dmd_feedback_divider i_dmd_feedback_divider (
        .clk_in    (clk),
        .rst_n     (rst_n),
        .ratio     (ratio),
        .mod_ctl   (mod_ctl),
        .div_pulse (div_pulse),
        .div_half  (div_half)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int exp_m(input logic [14:0] r);
        return (int'(r[14:4]) < 15) ? 15 : int'(r[14:4]);
    endfunction

    function automatic int exp_a(input logic [14:0] r);
        return (int'(r[14:4]) < 15) ? 0 : int'(r[3:0]);
    endfunction

    function automatic int exp_n(input logic [14:0] r);
        return 16 * exp_m(r) + exp_a(r);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts negedge samples up to and including the next div_pulse sample.
    task automatic wait_pulse(output int n, output int mh, output int tg, output bit wide);
        logic last_half;
        last_half = div_half;
        n = 0; mh = 0; tg = 0; wide = 1'b0;
        forever begin
            @(negedge clk);
            n = n + 1;
            if (n == 1 && div_pulse) wide = 1'b1;
            if (mod_ctl) mh = mh + 1;
            if (div_half != last_half) tg = tg + 1;
            last_half = div_half;
            if (div_pulse && n > 1) break;
        end
    endtask

    task automatic run_ratio(input logic [14:0] r, input string tag);
        int n, mh, tg;
        bit wide;
        ratio = r;
        wait_pulse(n, mh, tg, wide);
        // R6: the cycle in progress keeps the previous ratio
        chk(n == prev_n, {"R6 ", tag}, n, prev_n);
        wait_pulse(n, mh, tg, wide);
        // R2 / R7: period of the new ratio
        chk(n == exp_n(r), {"R2/R7 ", tag}, n, exp_n(r));
        // R3: modulus-high time
        chk(mh == 17 * exp_a(r), {"R3 ", tag}, mh, 17 * exp_a(r));
        // R5: one half-rate toggle per division cycle
        chk(tg == 1, {"R5 ", tag}, tg, 1);
        // R4: pulse lasts one clock
        chk(!wide, {"R4 ", tag}, int'(wide), 0);
        prev_n = exp_n(r);
    endtask

    initial begin
        int n, mh, tg;
        bit wide;
        void'($urandom(32'd1935));
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk(mod_ctl == 1'b0, "R1 mod_ctl in reset", int'(mod_ctl), 0);
        chk(div_pulse == 1'b0, "R1 div_pulse in reset", int'(div_pulse), 0);
        chk(div_half == 1'b0, "R1 div_half in reset", int'(div_half), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: still quiet just after release
        chk(div_pulse == 1'b0, "R1 div_pulse after reset", int'(div_pulse), 0);
        chk(div_half == 1'b0, "R1 div_half after reset", int'(div_half), 0);
        wait_pulse(n, mh, tg, wide);
        prev_n = exp_n(15'd1000);

        run_ratio(15'd1000, "steady 1000");
        run_ratio(15'd240,  "min legal");
        run_ratio(15'd255,  "M=15 A=15");
        run_ratio(15'd4111, "A=15 mid");
        run_ratio(15'd100,  "below floor (R7)");
        run_ratio(15'd0,    "zero (R7)");
        run_ratio(15'd239,  "just below floor (R7)");
        for (int i = 0; i < 8; i++) begin
            logic [14:0] rr;
            rr = 15'($urandom_range(2000, 240));
            run_ratio(rr, "random");
        end
        run_ratio(15'd32767, "full scale");
        run_ratio(15'd496,   "back to small");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule